// File: doc/BRIEF.md
# PTP Timestamp Capture Register Bank

This block belongs to one switch port. It keeps the precise-time events of that port and lets a host read them over a plain 16-bit register interface. The frame paths send one-cycle event pulses. Each pulse carries a 32-bit capture time, a 16-bit sequence ID and, for arrivals, a message type. The bank holds three capture slots. Two of them take arrivals and one takes departures. For each arrival, a per-type pointer vector picks which of the two arrival slots records it.

Each slot is a group of four registers: a status word, the low time half, the high time half and the sequence ID. A slot that already holds a capture either takes the new event or refuses it, as a configuration bit decides, and its status records which of the two happened. The host frees a slot by writing zero to its status word. A level interrupt stays high while any slot whose interrupt is enabled holds a capture.

Top module: `ptp_tstamp_bank`

## Requirements
- R1: After reset, config word 0 reads 0x0001 (port timestamping disabled), config word 2 reads 0x0000, all three status words read 0x0000, and `irq` is low.
- R2: Reads return data on `reg_rdata` one cycle after `reg_rd` is sampled. Config word 0 is at address 0x00 and config word 2 is at 0x02. Only bits 1:0 of each can be written, and all other bits read zero. Slots sit at 0x08 (arrival 0), 0x0C (arrival 1) and 0x10 (departure). The word offsets within a slot are +0 status, +1 time[15:0], +2 time[31:16], +3 sequence ID.
- R3: An event into a slot that has its valid bit clear stores its time and sequence ID. The status becomes 0x0001: bit 0 is valid, and bits 2:1 = 00 mean normal.
- R4: Config 0 bit 1 clear: an event into a valid slot replaces its time and sequence ID. The status becomes 0x0003 (outcome 01, overwritten).
- R5: Config 0 bit 1 set: an event into a valid slot leaves time and sequence ID unchanged. The status becomes 0x0005 (outcome 10, discarded).
- R6: A host write of 0x0000 to a status word clears it to 0x0000. A nonzero write to a status word has no effect. If a zero write and a capture reach the same slot in the same cycle, the result is a fresh capture with status 0x0001.
- R7: Config 0 bit 0 set: no arrival event and no departure event changes any slot.
- R8: An arrival of message type n goes to arrival slot 1 when bit n of `arr_ptr` is 1. It goes to arrival slot 0 when that bit is 0, so an all-zero pointer routes every type to slot 0.
- R9: `irq` is a registered level. It is high one cycle after either of these holds: config 2 bit 0 is set and an arrival slot is valid, or config 2 bit 1 is set and the departure slot is valid.
- R10: A read of a slot's time-low word latches that slot's high half. A later read of time-high returns the latched half, even if a new capture has landed in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 5 | Host word address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered read data |
| arr_ptr | input | 16 | Arrival slot select, one bit per message type |
| arr_evt | input | 1 | Arrival event pulse |
| arr_type | input | 4 | Arrival message type |
| arr_time | input | 32 | Arrival capture time |
| arr_seq | input | 16 | Arrival sequence ID |
| dep_evt | input | 1 | Departure event pulse |
| dep_time | input | 32 | Departure capture time |
| dep_seq | input | 16 | Departure sequence ID |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters: 16-bit register words, which give 32-bit times, and a 4-bit message type, which gives a 16-entry pointer vector. With these values the bench can send one type to the second arrival slot while a neighbouring type still goes to slot 0. The full 32-bit split lets the coherent-pair test tell an old high half apart from a new one. The bench also drives a clear and a capture into the same slot in the same cycle, and it runs every slot through normal, overwritten and discarded.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;
  typedef enum logic [1:0] {
    OUT_NORMAL  = 2'b00,
    OUT_OVERWR  = 2'b01,
    OUT_DISCARD = 2'b10
  } outcome_e;

  localparam int NUM_SLOTS  = 3;   // arrival 0, arrival 1, departure
  localparam int SLOT_DEP   = 2;
  localparam int SLOT_QUAD0 = 2;   // first slot at word 0x08 = quad 2
  localparam int ADDR_CFG0  = 0;
  localparam int ADDR_CFG2  = 2;
endpackage

// File: rtl/ptp_ts_slot.sv
module ptp_ts_slot
  import ptp_ts_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int SEQ_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap,
  input  logic [2*REG_W-1:0]   cap_time,
  input  logic [SEQ_W-1:0]     cap_seq,
  input  logic                 keep_old,
  input  logic                 host_clr,
  input  logic                 snap_hi,
  output logic                 valid,
  output outcome_e             outcome,
  output logic [2*REG_W-1:0]   time_q,
  output logic [SEQ_W-1:0]     seq_q,
  output logic [REG_W-1:0]     hi_snap
);
  localparam int TIME_W = 2 * REG_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      outcome <= OUT_NORMAL;
      time_q  <= '0;
      seq_q   <= '0;
      hi_snap <= '0;
    end else begin
      if (snap_hi) hi_snap <= time_q[TIME_W-1:REG_W];
      if (cap && (!valid || host_clr)) begin
        valid   <= 1'b1;
        outcome <= OUT_NORMAL;
        time_q  <= cap_time;
        seq_q   <= cap_seq;
      end else if (cap && keep_old) begin
        outcome <= OUT_DISCARD;
      end else if (cap) begin
        outcome <= OUT_OVERWR;
        time_q  <= cap_time;
        seq_q   <= cap_seq;
      end else if (host_clr) begin
        valid   <= 1'b0;
        outcome <= OUT_NORMAL;
      end
    end
  end

  AST_FIRST_NORMAL: assert property (@(posedge clk) disable iff (rst)
    cap && !valid |=> valid && outcome == OUT_NORMAL && seq_q == $past(cap_seq)); // R3
  AST_OVERWRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    cap && valid && !host_clr && !keep_old |=> outcome == OUT_OVERWR && time_q == $past(cap_time)); // R4
  AST_DISCARD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    cap && valid && !host_clr && keep_old |=> outcome == OUT_DISCARD && $stable(time_q) && $stable(seq_q)); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    host_clr && !cap |=> !valid && outcome == OUT_NORMAL); // R6
  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (rst)
    !snap_hi |=> $stable(hi_snap)); // R10
endmodule

// File: rtl/ptp_ts_cfg.sv
module ptp_ts_cfg (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_cfg0,
  input  logic       wr_cfg2,
  input  logic [1:0] wbits,
  input  logic       arr_any_valid,
  input  logic       dep_valid,
  output logic       ptp_off,
  output logic       keep_old,
  output logic       arr_irq_en,
  output logic       dep_irq_en,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptp_off    <= 1'b1;
      keep_old   <= 1'b0;
      arr_irq_en <= 1'b0;
      dep_irq_en <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (wr_cfg0) {keep_old, ptp_off} <= wbits;
      if (wr_cfg2) {dep_irq_en, arr_irq_en} <= wbits;
      irq <= (arr_irq_en && arr_any_valid) || (dep_irq_en && dep_valid);
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !arr_irq_en && !dep_irq_en |=> !irq); // R9
  AST_IRQ_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    !arr_any_valid && !dep_valid |=> !irq); // R9
endmodule

// File: rtl/ptp_tstamp_bank.sv
module ptp_tstamp_bank
  import ptp_ts_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int SEQ_W  = 16,
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  input  logic [(1<<TYPE_W)-1:0]   arr_ptr,
  input  logic                     arr_evt,
  input  logic [TYPE_W-1:0]        arr_type,
  input  logic [2*REG_W-1:0]       arr_time,
  input  logic [SEQ_W-1:0]         arr_seq,
  input  logic                     dep_evt,
  input  logic [2*REG_W-1:0]       dep_time,
  input  logic [SEQ_W-1:0]         dep_seq,
  output logic                     irq
);
  localparam int TIME_W = 2 * REG_W;

  logic ptp_off, keep_old, arr_irq_en, dep_irq_en;
  logic to_slot1;
  logic [NUM_SLOTS-1:0] cap_v, clr_v, snap_v, slot_valid;
  outcome_e             slot_out  [NUM_SLOTS];
  logic [TIME_W-1:0]    slot_time [NUM_SLOTS];
  logic [SEQ_W-1:0]     slot_seq  [NUM_SLOTS];
  logic [REG_W-1:0]     slot_snap [NUM_SLOTS];
  logic [REG_W-1:0]     rd_mux;

  assign to_slot1 = arr_ptr[arr_type];

  ptp_ts_cfg u_cfg (
    .clk          (clk),
    .rst          (rst),
    .wr_cfg0      (reg_wr && reg_addr == ADDR_W'(ADDR_CFG0)),
    .wr_cfg2      (reg_wr && reg_addr == ADDR_W'(ADDR_CFG2)),
    .wbits        (reg_wdata[1:0]),
    .arr_any_valid(slot_valid[0] || slot_valid[1]),
    .dep_valid    (slot_valid[SLOT_DEP]),
    .ptp_off      (ptp_off),
    .keep_old     (keep_old),
    .arr_irq_en   (arr_irq_en),
    .dep_irq_en   (dep_irq_en),
    .irq          (irq)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'((SLOT_QUAD0 + i) * 4);
    logic [TIME_W-1:0] in_time;
    logic [SEQ_W-1:0]  in_seq;
    if (i == SLOT_DEP) begin : g_dep
      assign cap_v[i] = dep_evt && !ptp_off;
      assign in_time  = dep_time;
      assign in_seq   = dep_seq;
    end else begin : g_arr
      assign cap_v[i] = arr_evt && !ptp_off && (to_slot1 == (i == 1));
      assign in_time  = arr_time;
      assign in_seq   = arr_seq;
    end
    assign clr_v[i]  = reg_wr && reg_addr == BASE && reg_wdata == '0;
    assign snap_v[i] = reg_rd && reg_addr == BASE + ADDR_W'(1);

    ptp_ts_slot #(.REG_W(REG_W), .SEQ_W(SEQ_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .cap     (cap_v[i]),
      .cap_time(in_time),
      .cap_seq (in_seq),
      .keep_old(keep_old),
      .host_clr(clr_v[i]),
      .snap_hi (snap_v[i]),
      .valid   (slot_valid[i]),
      .outcome (slot_out[i]),
      .time_q  (slot_time[i]),
      .seq_q   (slot_seq[i]),
      .hi_snap (slot_snap[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADDR_CFG0)) rd_mux[1:0] = {keep_old, ptp_off};
    if (reg_addr == ADDR_W'(ADDR_CFG2)) rd_mux[1:0] = {dep_irq_en, arr_irq_en};
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(SLOT_QUAD0 + i)) begin
        case (reg_addr[1:0])
          2'd0: rd_mux = {{(REG_W-3){1'b0}}, slot_out[i], slot_valid[i]};
          2'd1: rd_mux = slot_time[i][REG_W-1:0];
          2'd2: rd_mux = slot_snap[i];
          default: rd_mux = REG_W'(slot_seq[i]);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ptp_off && !slot_valid[0] && !slot_valid[SLOT_DEP] |=> !slot_valid[0] && !slot_valid[SLOT_DEP]); // R7
  AST_ROUTE_SLOT0: assert property (@(posedge clk) disable iff (rst)
    arr_evt && !ptp_off && !arr_ptr[arr_type] && !slot_valid[1] |=> !slot_valid[1]); // R8
  AST_ROUTE_SLOT1: assert property (@(posedge clk) disable iff (rst)
    arr_evt && !ptp_off && arr_ptr[arr_type] && !slot_valid[0] |=> !slot_valid[0]); // R8
endmodule

// File: tb/ptp_tstamp_bank_bench.sv
`timescale 1ns/1ps
module ptp_tstamp_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] arr_ptr = '0;
  logic        arr_evt = 0;
  logic [3:0]  arr_type = '0;
  logic [31:0] arr_time = '0;
  logic [15:0] arr_seq = '0;
  logic        dep_evt = 0;
  logic [31:0] dep_time = '0;
  logic [15:0] dep_seq = '0;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [15:0] exp; string tag; logic [4:0] addr; } rd_item_t;
  rd_item_t sb_q[$];

  always #2 clk = ~clk;

  ptp_tstamp_bank u_ptp_tstamp_bank (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_ptr(arr_ptr), .arr_evt(arr_evt),
    .arr_type(arr_type), .arr_time(arr_time), .arr_seq(arr_seq), .dep_evt(dep_evt),
    .dep_time(dep_time), .dep_seq(dep_seq), .irq(irq)
  );

  // monitor: pops the scoreboard one cycle after each read strobe
  initial begin
    forever begin
      logic p;
      @(posedge clk);
      p = reg_rd;
      @(negedge clk);
      if (p && sb_q.size() > 0) begin
        rd_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (reg_rdata !== it.exp) begin
          failures++;
          $display("FAIL %s addr=0x%02h actual=0x%04h expected=0x%04h", it.tag, it.addr, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic host_rd(input logic [4:0] a, input logic [15:0] e, input string tag);
    sb_q.push_back('{exp: e, tag: tag, addr: a});
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic host_wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic arrive(input logic [3:0] t, input logic [31:0] tm, input logic [15:0] s);
    arr_type = t; arr_time = tm; arr_seq = s; arr_evt = 1;
    @(negedge clk);
    arr_evt = 0;
  endtask

  task automatic depart(input logic [31:0] tm, input logic [15:0] s);
    dep_time = tm; dep_seq = s; dep_evt = 1;
    @(negedge clk);
    dep_evt = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (irq !== 1'b0) begin failures++; $display("FAIL R1 irq actual=%0b expected=0", irq); end
    host_rd(5'h00, 16'h0001, "R1 cfg0");
    host_rd(5'h02, 16'h0000, "R1 cfg2");
    host_rd(5'h08, 16'h0000, "R1 arr0 status");
    host_rd(5'h0C, 16'h0000, "R1 arr1 status");
    host_rd(5'h10, 16'h0000, "R1 dep status");
    // R7 disabled port ignores events
    arrive(4'd0, 32'h01020304, 16'h0011);
    depart(32'h05060708, 16'h0022);
    host_rd(5'h08, 16'h0000, "R7 arr0 untouched");
    host_rd(5'h10, 16'h0000, "R7 dep untouched");
    // R2 writable bits only
    host_wr(5'h00, 16'hFFFF);
    host_rd(5'h00, 16'h0003, "R2 cfg0 mask");
    host_wr(5'h00, 16'h0000);
    host_rd(5'h00, 16'h0000, "R2 cfg0 enable");
    // R3 first capture
    arrive(4'd0, 32'h12345678, 16'h00AA);
    host_rd(5'h08, 16'h0001, "R3 status");
    host_rd(5'h09, 16'h5678, "R3 time lo");
    host_rd(5'h0A, 16'h1234, "R3 time hi");
    host_rd(5'h0B, 16'h00AA, "R3 seq");
    // R9 irq gating
    chk_irq(1'b0, "R9 masked");
    host_wr(5'h02, 16'h0001);
    chk_irq(1'b1, "R9 arrival enabled");
    host_wr(5'h02, 16'h0002);
    chk_irq(1'b0, "R9 departure only, dep empty");
    // R4 overwrite
    arrive(4'd0, 32'h9ABCDEF0, 16'h00BB);
    host_rd(5'h08, 16'h0003, "R4 status");
    host_rd(5'h09, 16'hDEF0, "R4 time lo");
    host_rd(5'h0A, 16'h9ABC, "R4 time hi");
    host_rd(5'h0B, 16'h00BB, "R4 seq");
    // R5 discard
    host_wr(5'h00, 16'h0002);
    arrive(4'd0, 32'h11112222, 16'h00CC);
    host_rd(5'h08, 16'h0005, "R5 status");
    host_rd(5'h09, 16'hDEF0, "R5 time lo kept");
    host_rd(5'h0A, 16'h9ABC, "R5 time hi kept");
    host_rd(5'h0B, 16'h00BB, "R5 seq kept");
    // R6 clear semantics
    host_wr(5'h08, 16'h0004);
    host_rd(5'h08, 16'h0005, "R6 nonzero write ignored");
    host_wr(5'h08, 16'h0000);
    host_rd(5'h08, 16'h0000, "R6 zero write clears");
    // R8 routing
    arr_ptr = 16'h0020;
    arrive(4'd5, 32'h00C0FFEE, 16'h0007);
    host_rd(5'h0C, 16'h0001, "R8 type5 to slot1");
    host_rd(5'h08, 16'h0000, "R8 slot0 untouched");
    host_rd(5'h0D, 16'hFFEE, "R8 slot1 lo");
    host_rd(5'h0E, 16'h00C0, "R8 slot1 hi");
    host_rd(5'h0F, 16'h0007, "R8 slot1 seq");
    arrive(4'd4, 32'h44440000, 16'h0004);
    host_rd(5'h08, 16'h0001, "R8 type4 to slot0");
    // R6 clear and capture together
    host_wr(5'h00, 16'h0002);
    reg_addr = 5'h0C; reg_wdata = 16'h0000; reg_wr = 1;
    arr_type = 4'd5; arr_time = 32'h7777AAAA; arr_seq = 16'h0099; arr_evt = 1;
    @(negedge clk);
    reg_wr = 0; arr_evt = 0;
    host_rd(5'h0C, 16'h0001, "R6 clear+capture status");
    host_rd(5'h0F, 16'h0099, "R6 clear+capture seq");
    // R9 departure interrupt
    host_wr(5'h00, 16'h0000);
    depart(32'hAAAA5555, 16'h0101);
    chk_irq(1'b1, "R9 departure valid");
    // R10 coherent halves
    host_rd(5'h11, 16'h5555, "R10 lo first");
    depart(32'hBBBB6666, 16'h0202);
    host_rd(5'h12, 16'hAAAA, "R10 hi from same capture");
    host_rd(5'h11, 16'h6666, "R10 new lo");
    host_rd(5'h12, 16'hBBBB, "R10 new hi");
    host_rd(5'h13, 16'h0202, "R10 new seq");
    host_rd(5'h10, 16'h0003, "R4 dep overwritten");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule